// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between the execute stage of a 32-bit core and a synchronous data memory. The memory has a byte-enable write port and one cycle of read latency. For a store, the unit takes the effective address, the access width and the source register value. In the same cycle it drives the memory address, the write data placed on the byte lanes, a write-request strobe and a 4-bit byte-write mask. The memory commits the write on the next rising clock edge.

For a load, the unit presents the address, and the memory answers with the full word one cycle later. The unit keeps the low address bits, the width and the signedness of the request in registers. In the following cycle it uses them to pick the addressed byte or halfword out of the returned word and to sign- or zero-extend it to 32 bits.

Accesses that do not fall on their natural boundary are never split into parts. Instead, the unit raises a misaligned-load or misaligned-store flag together with the matching exception cause code. A misaligned store leaves memory untouched. Trap handling itself is left to the core.

Top module: `lsu_lane_align`

## Requirements
- R1: A word store (`op_funct3` = 010) on an address with low bits 00 drives `mem_wdata` equal to the source value, `mem_wmask` = 1111 and `mem_wreq` = 1 in the same cycle, with `mem_addr` equal to `op_addr`.
- R2: A halfword store (`op_funct3` = 001) puts the low 16 bits of the source in both halves of `mem_wdata`. The mask is 0011 when address bit 1 is 0 and 1100 when it is 1.
- R3: A byte store (`op_funct3` = 000) puts the low 8 bits of the source in all four lanes of `mem_wdata`. The mask has the single bit set at position `op_addr[1:0]`, so offset 01 gives 0010.
- R4: When `op_store` is low, `mem_wreq` is 0 and `mem_wmask` is 0000, whatever the address, width and data are.
- R5: A store is misaligned in two cases: a halfword with address bit 0 set, or a word with address bits [1:0] not 00. A misaligned store raises `st_misalign`, drives `exc_cause` = 6, and keeps `mem_wreq` = 0 and `mem_wmask` = 0000.
- R6: A load that is misaligned under the same rule raises `ld_misalign` and drives `exc_cause` = 4 in the request cycle. `ld_valid` stays 0 in the cycle after.
- R7: An aligned load raises `ld_valid` exactly one cycle after the request, and `ld_data` is taken from the `mem_rdata` of that cycle. A word load (`op_funct3` = 010) returns `mem_rdata` unchanged.
- R8: A signed byte load (000) or signed halfword load (001) replicates the top bit of the selected field into all upper bits of `ld_data`.
- R9: An unsigned byte load (100) or unsigned halfword load (101) fills the upper bits of `ld_data` with zeros. Bit 2 of `op_funct3` selects zero-extension, and bits [1:0] select the width: 00 byte, 01 halfword, 10 word.
- R10: The lane of a load is chosen from the address registered in the request cycle. A byte at offset k comes from `mem_rdata[8k+7:8k]`, and a halfword at offset 2 comes from bits [31:16]. Changing `op_addr` or `op_funct3` in the result cycle does not change `ld_data`.
- R11: While `rst_n` is low at a clock edge, `ld_valid` becomes 0 even if a load is requested. `exc_cause` is 0 whenever no misaligned flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_load | input | 1 | Load request this cycle |
| op_store | input | 1 | Store request this cycle |
| op_funct3 | input | 3 | Width and signedness encoding |
| op_addr | input | 32 | Effective byte address |
| op_wsrc | input | 32 | Store source register value |
| mem_addr | output | 32 | Address presented to memory |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_wreq | output | 1 | Write request strobe |
| mem_wmask | output | 4 | Byte-write enable mask |
| mem_rdata | input | 32 | Word returned by memory, one cycle after the address |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extracted and extended load result |
| ld_misalign | output | 1 | Misaligned load flag |
| st_misalign | output | 1 | Misaligned store flag |
| exc_cause | output | 4 | Exception cause code: 6 store, 4 load, 0 none |

## Verification
Some properties are checked by assertions on every cycle:
- a misaligned store never writes;
- the two misaligned flags never rise together and always agree with the cause code;
- the mask has one bit set for byte stores and two for halfword stores;
- extended load results have all upper bits equal to the sign bit (signed forms) or to zero (unsigned forms);
- a misaligned load is never followed by a valid result.

Other behaviour depends on concrete data and on the order of cycles, so only the bench's scenarios can show it. This covers the exact lane placement and replication of store data, the byte picked from the returned word, the use of the registered rather than the current address in the result cycle, and reset overriding a pending load.

// File: rtl/lsu_lane_pkg.sv
// Package: shared encodings for the load/store lane alignment unit.
// Assumes the usual three-bit width/signedness encoding of load and
// store operations: bits [1:0] give the width, bit 2 asks for zero-extension.
package lsu_lane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } lsu_size_e;

    localparam logic [3:0] CAUSE_NONE   = 4'd0;
    localparam logic [3:0] CAUSE_LD_MIS = 4'd4;
    localparam logic [3:0] CAUSE_ST_MIS = 4'd6;

endpackage

// File: rtl/lsu_align_check.sv
// Module: lsu_align_check
// Flags loads and stores whose address is not a multiple of the access
// width. Purely combinational. Assumes a reserved width code is treated
// like a word access.
module lsu_align_check
    import lsu_lane_pkg::*;
#(
    parameter int LANE_BITS = 2
) (
    input  logic                 ld_req,
    input  logic                 st_req,
    input  lsu_size_e            size,
    input  logic [LANE_BITS-1:0] addr_lo,
    output logic                 ld_mis,
    output logic                 st_mis
);

    logic off_bound;

    // Decide whether the low address bits break the natural boundary.
    always_comb begin
        case (size)
            SZ_BYTE: off_bound = 1'b0;
            SZ_HALF: off_bound = addr_lo[0];
            default: off_bound = (addr_lo != '0);
        endcase
    end

    assign ld_mis = ld_req & off_bound;
    assign st_mis = st_req & off_bound;

endmodule

// File: rtl/lsu_store_pack.sv
// Module: lsu_store_pack
// Places store data on the memory byte lanes and builds the byte-write
// mask. Byte data is copied to every lane and halfword data to every half.
// The mask selects the lanes actually written. Assumes 'en' is already
// low for misaligned or absent stores.
module lsu_store_pack
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LANES     = DATA_W / 8,
    parameter int LANE_BITS = $clog2(LANES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  lsu_size_e            size,
    input  logic [LANE_BITS-1:0] addr_lo,
    input  logic [DATA_W-1:0]    src,
    output logic [DATA_W-1:0]    wdata,
    output logic [LANES-1:0]     wmask
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_hit;

        // Pick the source byte for this lane according to the width.
        assign wdata[8*g +: 8] = (size == SZ_BYTE) ? src[7:0] :
                                 (size == SZ_HALF) ? src[8*(g%2) +: 8] :
                                                     src[8*g +: 8];

        // Decide whether this lane lies inside the addressed field.
        assign lane_hit = (size == SZ_BYTE) ? (addr_lo == LANE_BITS'(g)) :
                          (size == SZ_HALF) ? (addr_lo[LANE_BITS-1:1] == (LANE_BITS-1)'(g / 2)) :
                                              1'b1;

        assign wmask[g] = en & lane_hit;
    end

    // Byte stores touch exactly one lane.
    assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && size == SZ_BYTE) |-> ($countones(wmask) == 1));

    // Halfword stores touch exactly two lanes.
    assert_half_two_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && size == SZ_HALF) |-> ($countones(wmask) == 2));

endmodule

// File: rtl/lsu_load_extract.sv
// Module: lsu_load_extract
// Registers the low address bits, width and signedness of an accepted load.
// In the next cycle it selects and extends the addressed field of the word
// returned by memory. Assumes memory read latency is exactly one cycle.
module lsu_load_extract
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LANES     = DATA_W / 8,
    parameter int LANE_BITS = $clog2(LANES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  lsu_size_e            size,
    input  logic                 zext,
    input  logic [LANE_BITS-1:0] addr_lo,
    input  logic [DATA_W-1:0]    rdata,
    output logic                 valid,
    output logic [DATA_W-1:0]    result
);

    lsu_size_e            size_q;
    logic                 zext_q;
    logic [LANE_BITS-1:0] lo_q;
    logic [7:0]           byte_sel;
    logic [15:0]          half_sel;

    // Hold the load attributes for the cycle in which memory answers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            size_q <= SZ_BYTE;
            zext_q <= 1'b0;
            lo_q   <= '0;
        end else begin
            valid <= capture;
            if (capture) begin
                size_q <= size;
                zext_q <= zext;
                lo_q   <= addr_lo;
            end
        end
    end

    // Select the addressed byte and halfword from the returned word.
    always_comb begin
        byte_sel = rdata[8*int'(lo_q) +: 8];
        half_sel = rdata[16*int'(lo_q[LANE_BITS-1:1]) +: 16];
    end

    // Extend the selected field to the full data width.
    always_comb begin
        case (size_q)
            SZ_BYTE: result = {{(DATA_W-8){~zext_q & byte_sel[7]}}, byte_sel};
            SZ_HALF: result = {{(DATA_W-16){~zext_q & half_sel[15]}}, half_sel};
            default: result = rdata;
        endcase
    end

    // Signed narrow loads copy the field's top bit upward.
    assert_sign_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !zext_q && size_q == SZ_BYTE) |-> (result[DATA_W-1:8] == {(DATA_W-8){result[7]}}));

    // Unsigned narrow loads clear the upper bits.
    assert_zero_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && zext_q && size_q == SZ_HALF) |-> (result[DATA_W-1:16] == '0));

endmodule

// File: rtl/lsu_lane_align.sv
// Module: lsu_lane_align (top)
// Load/store byte-lane alignment between execute and a synchronous data
// memory with byte-write mask and one-cycle read latency. Misaligned
// accesses raise a flag and a cause code instead of being split.
// Assumes op_load and op_store are never high together.
module lsu_lane_align
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_load,
    input  logic                op_store,
    input  logic [2:0]          op_funct3,
    input  logic [ADDR_W-1:0]   op_addr,
    input  logic [DATA_W-1:0]   op_wsrc,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                mem_wreq,
    output logic [DATA_W/8-1:0] mem_wmask,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                ld_valid,
    output logic [DATA_W-1:0]   ld_data,
    output logic                ld_misalign,
    output logic                st_misalign,
    output logic [3:0]          exc_cause
);

    localparam int LANES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(LANES);

    lsu_size_e            size;
    logic [LANE_BITS-1:0] addr_lo;
    logic                 st_go;

    assign size     = lsu_size_e'(op_funct3[1:0]);
    assign addr_lo  = op_addr[LANE_BITS-1:0];
    assign mem_addr = op_addr;

    lsu_align_check #(.LANE_BITS(LANE_BITS)) i_check (
        .ld_req  (op_load),
        .st_req  (op_store),
        .size    (size),
        .addr_lo (addr_lo),
        .ld_mis  (ld_misalign),
        .st_mis  (st_misalign)
    );

    assign st_go    = op_store & ~st_misalign;
    assign mem_wreq = st_go;

    lsu_store_pack #(.DATA_W(DATA_W), .LANES(LANES), .LANE_BITS(LANE_BITS)) i_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (st_go),
        .size    (size),
        .addr_lo (addr_lo),
        .src     (op_wsrc),
        .wdata   (mem_wdata),
        .wmask   (mem_wmask)
    );

    lsu_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .LANE_BITS(LANE_BITS)) i_extract (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (op_load & ~ld_misalign),
        .size    (size),
        .zext    (op_funct3[2]),
        .addr_lo (addr_lo),
        .rdata   (mem_rdata),
        .valid   (ld_valid),
        .result  (ld_data)
    );

    // Report the exception cause, store first.
    always_comb begin
        if (st_misalign)      exc_cause = CAUSE_ST_MIS;
        else if (ld_misalign) exc_cause = CAUSE_LD_MIS;
        else                  exc_cause = CAUSE_NONE;
    end

    // A misaligned store never reaches memory.
    assert_mis_store_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_misalign |-> (!mem_wreq && mem_wmask == '0));

    // Without a store request nothing is written.
    assert_idle_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !op_store |-> (!mem_wreq && mem_wmask == '0));

    // A misaligned load never produces a result.
    assert_mis_load_no_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_misalign |=> !ld_valid);

    // The two flags are exclusive and the cause is quiet without a flag.
    assert_cause_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_misalign && st_misalign) && ((ld_misalign || st_misalign) || exc_cause == CAUSE_NONE));

endmodule

// File: tb/test_lsu_lane_align.sv
module test_lsu_lane_align;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;

    typedef struct packed {
        logic        is_st;
        logic [2:0]  f3;
        logic [31:0] addr;
        logic [31:0] wsrc;
        logic [31:0] rdata;
        logic [31:0] exp_wdata;
        logic [3:0]  exp_mask;
        logic        exp_mis;
        logic [3:0]  exp_cause;
        logic        exp_lv;
        logic [31:0] exp_ld;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        // R1 word store
        '{1'b1, 3'b010, 32'h100, 32'h12345678, 32'h0, 32'h12345678, 4'hF, 1'b0, 4'd0, 1'b0, 32'h0, 4'd1},
        // R2 halfword store, upper half
        '{1'b1, 3'b001, 32'h102, 32'h0000ABCD, 32'h0, 32'hABCDABCD, 4'hC, 1'b0, 4'd0, 1'b0, 32'h0, 4'd2},
        // R2 halfword store, lower half
        '{1'b1, 3'b001, 32'h100, 32'hFFFF1234, 32'h0, 32'h12341234, 4'h3, 1'b0, 4'd0, 1'b0, 32'h0, 4'd2},
        // R3 byte store offset 1
        '{1'b1, 3'b000, 32'h101, 32'h000000EF, 32'h0, 32'hEFEFEFEF, 4'h2, 1'b0, 4'd0, 1'b0, 32'h0, 4'd3},
        // R3 byte store offset 3
        '{1'b1, 3'b000, 32'h103, 32'h11223344, 32'h0, 32'h44444444, 4'h8, 1'b0, 4'd0, 1'b0, 32'h0, 4'd3},
        // R5 misaligned halfword store
        '{1'b1, 3'b001, 32'h101, 32'h0000ABCD, 32'h0, 32'hABCDABCD, 4'h0, 1'b1, 4'd6, 1'b0, 32'h0, 4'd5},
        // R5 misaligned word store
        '{1'b1, 3'b010, 32'h102, 32'hDEADBEEF, 32'h0, 32'hDEADBEEF, 4'h0, 1'b1, 4'd6, 1'b0, 32'h0, 4'd5},
        // R7 word load
        '{1'b0, 3'b010, 32'h200, 32'h0, 32'h89ABCDEF, 32'h0, 4'h0, 1'b0, 4'd0, 1'b1, 32'h89ABCDEF, 4'd7},
        // R8 signed byte load offset 1
        '{1'b0, 3'b000, 32'h201, 32'h0, 32'h123480FF, 32'h0, 4'h0, 1'b0, 4'd0, 1'b1, 32'hFFFFFF80, 4'd8},
        // R9 unsigned byte load offset 1
        '{1'b0, 3'b100, 32'h201, 32'h0, 32'h123480FF, 32'h0, 4'h0, 1'b0, 4'd0, 1'b1, 32'h00000080, 4'd9},
        // R8 signed halfword load upper half
        '{1'b0, 3'b001, 32'h202, 32'h0, 32'h80017FFF, 32'h0, 4'h0, 1'b0, 4'd0, 1'b1, 32'hFFFF8001, 4'd8},
        // R9 unsigned halfword load upper half
        '{1'b0, 3'b101, 32'h202, 32'h0, 32'h80017FFF, 32'h0, 4'h0, 1'b0, 4'd0, 1'b1, 32'h00008001, 4'd9},
        // R8 signed halfword load lower half, positive
        '{1'b0, 3'b001, 32'h200, 32'h0, 32'h80017FFF, 32'h0, 4'h0, 1'b0, 4'd0, 1'b1, 32'h00007FFF, 4'd8},
        // R10 byte load offset 3
        '{1'b0, 3'b000, 32'h203, 32'h0, 32'h7F000000, 32'h0, 4'h0, 1'b0, 4'd0, 1'b1, 32'h0000007F, 4'd10},
        // R6 misaligned word load
        '{1'b0, 3'b010, 32'h201, 32'h0, 32'hFFFFFFFF, 32'h0, 4'h0, 1'b1, 4'd4, 1'b0, 32'h0, 4'd6},
        // R6 misaligned halfword load
        '{1'b0, 3'b101, 32'h203, 32'h0, 32'hFFFFFFFF, 32'h0, 4'h0, 1'b1, 4'd4, 1'b0, 32'h0, 4'd6},
        // R3 byte store offset 0
        '{1'b1, 3'b000, 32'h104, 32'h000000A5, 32'h0, 32'hA5A5A5A5, 4'h1, 1'b0, 4'd0, 1'b0, 32'h0, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_load = 1'b0;
    logic        op_store = 1'b0;
    logic [2:0]  op_funct3 = 3'b000;
    logic [31:0] op_addr = '0;
    logic [31:0] op_wsrc = '0;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_wreq;
    logic [3:0]  mem_wmask;
    logic [31:0] mem_rdata = '0;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic        ld_misalign;
    logic        st_misalign;
    logic [3:0]  exc_cause;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_lane_align i_lsu_lane_align (
        .clk, .rst_n, .op_load, .op_store, .op_funct3, .op_addr, .op_wsrc,
        .mem_addr, .mem_wdata, .mem_wreq, .mem_wmask, .mem_rdata,
        .ld_valid, .ld_data, .ld_misalign, .st_misalign, .exc_cause
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11 reset state
        repeat (2) @(negedge clk);
        #1 check("R11 reset ld_valid", {31'b0, ld_valid}, 32'h0);
        check("R11 reset cause", {28'b0, exc_cause}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_store  = VECS[i].is_st;
            op_load   = ~VECS[i].is_st;
            op_funct3 = VECS[i].f3;
            op_addr   = VECS[i].addr;
            op_wsrc   = VECS[i].wsrc;
            mem_rdata = '0;
            #1;
            check($sformatf("R%0d vec%0d addr", VECS[i].req, i), mem_addr, VECS[i].addr);
            check($sformatf("R%0d vec%0d wdata", VECS[i].req, i), mem_wdata, VECS[i].exp_wdata);
            check($sformatf("R%0d vec%0d mask", VECS[i].req, i), {28'b0, mem_wmask}, {28'b0, VECS[i].exp_mask});
            check($sformatf("R%0d vec%0d wreq", VECS[i].req, i), {31'b0, mem_wreq},
                  {31'b0, VECS[i].is_st & ~VECS[i].exp_mis});
            check($sformatf("R%0d vec%0d misalign", VECS[i].req, i), {31'b0, ld_misalign | st_misalign},
                  {31'b0, VECS[i].exp_mis});
            check($sformatf("R%0d vec%0d cause", VECS[i].req, i), {28'b0, exc_cause}, {28'b0, VECS[i].exp_cause});
            @(negedge clk);
            op_store  = 1'b0;
            op_load   = 1'b0;
            mem_rdata = VECS[i].rdata;
            #1;
            check($sformatf("R%0d vec%0d ld_valid", VECS[i].req, i), {31'b0, ld_valid}, {31'b0, VECS[i].exp_lv});
            if (VECS[i].exp_lv)
                check($sformatf("R%0d vec%0d ld_data", VECS[i].req, i), ld_data, VECS[i].exp_ld);
        end

        // R4 idle: no store request means no write
        @(negedge clk);
        op_store = 1'b0; op_load = 1'b0; op_funct3 = 3'b000; op_addr = 32'h101; op_wsrc = 32'hFF;
        #1 check("R4 idle mask", {28'b0, mem_wmask}, 32'h0);
        check("R4 idle wreq", {31'b0, mem_wreq}, 32'h0);

        // R10 result lane from registered address, inputs changed in result cycle
        @(negedge clk);
        op_load = 1'b1; op_funct3 = 3'b000; op_addr = 32'h202;
        @(negedge clk);
        op_load = 1'b0; op_funct3 = 3'b010; op_addr = 32'h200; mem_rdata = 32'h00C30000;
        #1 check("R10 registered lane", ld_data, 32'hFFFFFFC3);
        check("R10 valid", {31'b0, ld_valid}, 32'h1);

        // R7 valid lasts one cycle only
        @(negedge clk);
        #1 check("R7 single-cycle valid", {31'b0, ld_valid}, 32'h0);

        // R11 reset overrides a pending load
        @(negedge clk);
        op_load = 1'b1; op_funct3 = 3'b010; op_addr = 32'h300; rst_n = 1'b0;
        @(negedge clk);
        op_load = 1'b0;
        #1 check("R11 reset drops load", {31'b0, ld_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule